// File: doc/BRIEF.md
# Priority-Sorted Pending Request List

This block keeps a bounded set of pending cache requests sorted by priority, so that the request the cache should serve next is always available at the head output without a search. Each pending request carries a numeric priority (zero is the most urgent), a small kind code and an identifier chosen by the requester. Storage is a fixed pool of slots joined into a doubly linked list in priority order. Slots not in use are chained into a separate free list.

A requester offers a new request on the insert port. The block places it after every pending request of equal or lower numeric priority, so requests of the same priority are served in arrival order. A consumer, or any other agent that cancels a request, removes it by identifier from any position in the list. The neighbours are relinked and the slot goes back to the free list. Full and empty flags let the surrounding logic throttle insertion and detect idle periods. Carrying out the requests is left to the logic around the block.

Top module: `pq_list`

## Requirements
- R1: After reset the list is empty: `empty`=1, `full`=0, `head_valid`=0 and `rem_err`=0.
- R2: Whenever the list holds entries, `head_prio`/`head_kind`/`head_id` show an entry with the smallest numeric priority present (0 is most urgent).
- R3: Entries of equal priority leave the list in the order they were inserted. A new entry goes ahead of the first entry whose priority is strictly greater than its own.
- R4: An insert offered while the list is not full is accepted at the clock edge. Its effect is visible on the outputs right after that edge, and inserting into an empty list makes the new entry the head.
- R5: After NUM_SLOTS accepted inserts with no removals, `full`=1. An insert offered while full is dropped and leaves the list contents unchanged.
- R6: A remove names an identifier. The matching entry is taken out of any position, and the remaining entries keep their relative order.
- R7: Removing the head entry makes its successor the new head. Removing the last entry sets `empty`=1.
- R8: A remove naming an identifier that is not pending leaves the list unchanged. `rem_err` is then 1 for exactly the one cycle after that edge.
- R9: When insert and remove are offered in the same cycle, the remove is carried out and the insert is dropped.
- R10: Slots freed by removals are reused. After the list has been emptied, NUM_SLOTS new inserts are accepted again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Offer a new request this cycle |
| ins_prio | input | PRIO_W | Priority of the new request, 0 most urgent |
| ins_kind | input | KIND_W | Kind code of the new request |
| ins_id | input | ID_W | Identifier of the new request |
| rem_valid | input | 1 | Remove the request named by rem_id this cycle |
| rem_id | input | ID_W | Identifier of the request to remove |
| head_valid | output | 1 | Head outputs hold a pending request |
| head_prio | output | PRIO_W | Priority of the head request |
| head_kind | output | KIND_W | Kind of the head request |
| head_id | output | ID_W | Identifier of the head request |
| full | output | 1 | No free slot is left |
| empty | output | 1 | No request is pending |
| rem_err | output | 1 | The previous remove named an identifier that was not pending |

## Verification
The bench mixes priorities so that new entries land at the head, in the middle and at the tail, and it repeats equal priorities. A design that broke ties the wrong way, or linked a new entry at the wrong neighbour, would then drain in an order different from the reference list. It removes entries from the middle and from the head. A wrong predecessor or successor relink would lose the tail or leave a stale head. It also fills all slots, offers one extra insert, offers an insert together with a remove, and removes an absent identifier. A block that leaked or double-issued slots, let an insert slip through in those cycles, or corrupted the list on a miss would show an extra entry, a missing entry or a missing error pulse when the list is drained and refilled.

// File: rtl/pq_pkg.sv
package pq_pkg;
   // Upper bound on the slot pool accepted by the list
   localparam int unsigned PQ_MAX_SLOTS = 64;

   // Operation carried out by the list in a cycle
   typedef enum logic [1:0] {
      PQ_OP_IDLE   = 2'd0,
      PQ_OP_INSERT = 2'd1,
      PQ_OP_REMOVE = 2'd2,
      PQ_OP_REJECT = 2'd3
   } pq_op_e;
endpackage

// File: rtl/pq_onehot_enc.sv
module pq_onehot_enc #(
   parameter int unsigned WIDTH = 16,
   localparam int unsigned IW   = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] hot,
   output logic [IW-1:0]    idx,
   output logic             any
);
   always_comb begin
      idx = '0;
      for (int unsigned i = 0; i < WIDTH; i++) begin
         if (hot[i]) idx = idx | IW'(i);
      end
   end
   assign any = |hot;
endmodule

// File: rtl/pq_find_pred.sv
module pq_find_pred #(
   parameter int unsigned NUM_SLOTS = 16,
   parameter int unsigned PRIO_W    = 4,
   localparam int unsigned IW       = $clog2(NUM_SLOTS),
   localparam int unsigned PW       = IW + 1
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [NUM_SLOTS-1:0]               valid,
   input  logic [NUM_SLOTS-1:0][PRIO_W-1:0]   prio,
   input  logic [NUM_SLOTS-1:0][PW-1:0]       nxt,
   input  logic [PRIO_W-1:0]                  new_prio,
   output logic                               found,
   output logic [IW-1:0]                      pred_idx
);
   logic [NUM_SLOTS-1:0] cand;

   // A slot is the predecessor when it does not outrank-lose to the new entry
   // and its successor (if any) has a strictly larger priority value.
   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      logic succ_gt;
      assign succ_gt = nxt[g][IW] ? 1'b1 : (prio[nxt[g][IW-1:0]] > new_prio);
      assign cand[g] = valid[g] && (prio[g] <= new_prio) && succ_gt;
   end

   pq_onehot_enc #(.WIDTH(NUM_SLOTS)) u_enc (
      .hot (cand),
      .idx (pred_idx),
      .any (found)
   );

   AST_PRED_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cand)); // R3
endmodule

// File: rtl/pq_find_id.sv
module pq_find_id #(
   parameter int unsigned NUM_SLOTS = 16,
   parameter int unsigned ID_W      = 8,
   localparam int unsigned IW       = $clog2(NUM_SLOTS)
) (
   input  logic [NUM_SLOTS-1:0]             valid,
   input  logic [NUM_SLOTS-1:0][ID_W-1:0]   ids,
   input  logic [ID_W-1:0]                  key,
   output logic                             hit,
   output logic [IW-1:0]                    hit_idx
);
   logic [NUM_SLOTS-1:0] match;

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
      assign match[g] = valid[g] && (ids[g] == key);
   end

   // Lowest-numbered matching slot wins if identifiers repeat
   always_comb begin
      hit_idx = '0;
      for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
         if (match[i]) hit_idx = IW'(i);
      end
   end
   assign hit = |match;
endmodule

// File: rtl/pq_list.sv
module pq_list #(
   parameter int unsigned NUM_SLOTS = 16,
   parameter int unsigned PRIO_W    = 4,
   parameter int unsigned KIND_W    = 2,
   parameter int unsigned ID_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins_valid,
   input  logic [PRIO_W-1:0] ins_prio,
   input  logic [KIND_W-1:0] ins_kind,
   input  logic [ID_W-1:0]   ins_id,
   input  logic              rem_valid,
   input  logic [ID_W-1:0]   rem_id,
   output logic              head_valid,
   output logic [PRIO_W-1:0] head_prio,
   output logic [KIND_W-1:0] head_kind,
   output logic [ID_W-1:0]   head_id,
   output logic              full,
   output logic              empty,
   output logic              rem_err
);
   import pq_pkg::*;

   localparam int unsigned IW  = $clog2(NUM_SLOTS);
   localparam int unsigned PW  = IW + 1;
   localparam logic [PW-1:0] NIL = {PW{1'b1}};

   // Elaboration-time parameter checks
   if (NUM_SLOTS < 2 || NUM_SLOTS > PQ_MAX_SLOTS || (1 << IW) != NUM_SLOTS) begin : g_bad_slots
      $error("pq_list: NUM_SLOTS must be a power of two between 2 and PQ_MAX_SLOTS");
   end
   if (PRIO_W < 1 || KIND_W < 1 || ID_W < 1) begin : g_bad_width
      $error("pq_list: field widths must be at least one bit");
   end

   logic [NUM_SLOTS-1:0]               valid_q;
   logic [NUM_SLOTS-1:0][PRIO_W-1:0]   prio_q;
   logic [NUM_SLOTS-1:0][KIND_W-1:0]   kind_q;
   logic [NUM_SLOTS-1:0][ID_W-1:0]     id_q;
   logic [NUM_SLOTS-1:0][PW-1:0]       nxt_q;
   logic [NUM_SLOTS-1:0][PW-1:0]       prv_q;
   logic [PW-1:0]                      head_q;
   logic [PW-1:0]                      free_q;
   logic                               err_q;

   logic          pred_found;
   logic [IW-1:0] pred_idx;
   logic          id_hit;
   logic [IW-1:0] hit_idx;
   pq_op_e        op;

   logic [IW-1:0] head_idx, alloc_idx, pred_nxt_idx, rm_prv_idx, rm_nxt_idx;
   logic [PW-1:0] pred_nxt, rm_prv, rm_nxt;

   assign head_idx     = head_q[IW-1:0];
   assign alloc_idx    = free_q[IW-1:0];
   assign pred_nxt     = nxt_q[pred_idx];
   assign pred_nxt_idx = pred_nxt[IW-1:0];
   assign rm_prv       = prv_q[hit_idx];
   assign rm_nxt       = nxt_q[hit_idx];
   assign rm_prv_idx   = rm_prv[IW-1:0];
   assign rm_nxt_idx   = rm_nxt[IW-1:0];

   pq_find_pred #(.NUM_SLOTS(NUM_SLOTS), .PRIO_W(PRIO_W)) u_pred (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid    (valid_q),
      .prio     (prio_q),
      .nxt      (nxt_q),
      .new_prio (ins_prio),
      .found    (pred_found),
      .pred_idx (pred_idx)
   );

   pq_find_id #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W)) u_id (
      .valid   (valid_q),
      .ids     (id_q),
      .key     (rem_id),
      .hit     (id_hit),
      .hit_idx (hit_idx)
   );

   // Remove has precedence; an insert is taken only when a slot is free
   always_comb begin
      if (rem_valid)                op = id_hit ? PQ_OP_REMOVE : PQ_OP_REJECT;
      else if (ins_valid && !full)  op = PQ_OP_INSERT;
      else                          op = PQ_OP_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         prio_q  <= '0;
         kind_q  <= '0;
         id_q    <= '0;
         head_q  <= NIL;
         free_q  <= '0;
         err_q   <= 1'b0;
         for (int unsigned i = 0; i < NUM_SLOTS; i++) begin
            nxt_q[i] <= (i == NUM_SLOTS - 1) ? NIL : PW'(i + 1);
            prv_q[i] <= NIL;
         end
      end else begin
         err_q <= (op == PQ_OP_REJECT);
         case (op)
            PQ_OP_INSERT: begin
               valid_q[alloc_idx] <= 1'b1;
               prio_q[alloc_idx]  <= ins_prio;
               kind_q[alloc_idx]  <= ins_kind;
               id_q[alloc_idx]    <= ins_id;
               free_q             <= nxt_q[alloc_idx];
               if (pred_found) begin
                  nxt_q[alloc_idx] <= pred_nxt;
                  prv_q[alloc_idx] <= {1'b0, pred_idx};
                  nxt_q[pred_idx]  <= free_q;
                  if (!pred_nxt[IW]) prv_q[pred_nxt_idx] <= free_q;
               end else begin
                  nxt_q[alloc_idx] <= head_q;
                  prv_q[alloc_idx] <= NIL;
                  head_q           <= free_q;
                  if (!head_q[IW]) prv_q[head_idx] <= free_q;
               end
            end
            PQ_OP_REMOVE: begin
               valid_q[hit_idx] <= 1'b0;
               nxt_q[hit_idx]   <= free_q;
               free_q           <= {1'b0, hit_idx};
               if (rm_prv[IW]) head_q <= rm_nxt;
               else            nxt_q[rm_prv_idx] <= rm_nxt;
               if (!rm_nxt[IW]) prv_q[rm_nxt_idx] <= rm_prv;
            end
            default: ;
         endcase
      end
   end

   assign head_valid = !head_q[IW];
   assign empty      = head_q[IW];
   assign full       = free_q[IW];
   assign head_prio  = prio_q[head_idx];
   assign head_kind  = kind_q[head_idx];
   assign head_id    = id_q[head_idx];
   assign rem_err    = err_q;

   AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty)); // R5
   AST_HEAD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (head_valid && !nxt_q[head_idx][IW]) |-> (head_prio <= prio_q[nxt_q[head_idx][IW-1:0]])); // R2
   AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (full && ins_valid && !rem_valid) |=> (full && $stable(head_q))); // R5
   AST_INS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && ins_valid && !rem_valid) |=> (head_valid && head_id == $past(ins_id))); // R4
   AST_MISS_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (rem_valid && !id_hit) |=> ($stable(head_q) && $stable(free_q) && $stable(valid_q))); // R8
   AST_BOTH_DROPS_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
      (rem_valid && ins_valid) |=> ($countones(valid_q) <= $past($countones(valid_q)))); // R9
   AST_ERR_AFTER_REMOVE: assert property (@(posedge clk) disable iff (!rst_n)
      rem_err |-> $past(rem_valid)); // R8
endmodule

// File: tb/pq_list_test.sv
module pq_list_test;
   localparam int NS = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ins_valid = 1'b0;
   logic [3:0] ins_prio = '0;
   logic [1:0] ins_kind = '0;
   logic [7:0] ins_id = '0;
   logic       rem_valid = 1'b0;
   logic [7:0] rem_id = '0;
   logic       head_valid, full, empty, rem_err;
   logic [3:0] head_prio;
   logic [1:0] head_kind;
   logic [7:0] head_id;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   typedef struct { int prio; int kind; int id; } item_t;
   item_t model[$];
   item_t sb[$];

   always #10 clk = ~clk;

   pq_list uut (
      .clk(clk), .rst_n(rst_n),
      .ins_valid(ins_valid), .ins_prio(ins_prio), .ins_kind(ins_kind), .ins_id(ins_id),
      .rem_valid(rem_valid), .rem_id(rem_id),
      .head_valid(head_valid), .head_prio(head_prio), .head_kind(head_kind), .head_id(head_id),
      .full(full), .empty(empty), .rem_err(rem_err)
   );

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Reference model: insert ahead of the first strictly larger priority
   task automatic model_insert(int p, int k, int id);
      int pos;
      item_t it;
      if (model.size() >= NS) return;
      pos = model.size();
      for (int j = 0; j < model.size(); j++) begin
         if (model[j].prio > p) begin pos = j; break; end
      end
      it.prio = p; it.kind = k; it.id = id;
      model.insert(pos, it);
   endtask

   function automatic bit model_remove(int id);
      for (int j = 0; j < model.size(); j++) begin
         if (model[j].id == id) begin model.delete(j); return 1'b1; end
      end
      return 1'b0;
   endfunction

   task automatic do_insert(int p, int id);
      @(negedge clk);
      ins_valid = 1'b1; ins_prio = 4'(p); ins_kind = 2'(id % 4); ins_id = 8'(id);
      @(negedge clk);
      ins_valid = 1'b0;
      model_insert(p, id % 4, id);
   endtask

   task automatic do_remove(string req, int id);
      bit present;
      @(negedge clk);
      rem_valid = 1'b1; rem_id = 8'(id);
      @(negedge clk);
      rem_valid = 1'b0;
      present = model_remove(id);
      chk(req, "rem_err", int'(rem_err), present ? 0 : 1);
   endtask

   // Monitor: pop the expected head from the scoreboard and compare
   task automatic mon_head(string req);
      item_t e;
      if (sb.size() == 0) return;
      e = sb.pop_front();
      chk(req, "head_valid", int'(head_valid), 1);
      chk(req, "head_prio", int'(head_prio), e.prio);
      chk(req, "head_kind", int'(head_kind), e.kind);
      chk(req, "head_id", int'(head_id), e.id);
   endtask

   // Driver side: push the model's head as the expected item
   task automatic expect_head(string req);
      if (model.size() == 0) begin
         chk(req, "empty", int'(empty), 1);
         chk(req, "head_valid", int'(head_valid), 0);
      end else begin
         sb.push_back(model[0]);
         mon_head(req);
      end
   endtask

   task automatic drain(string req);
      while (model.size() > 0) begin
         expect_head(req);
         do_remove(req, model[0].id);
      end
      chk(req, "empty after drain", int'(empty), 1);
      chk(req, "full after drain", int'(full), 0);
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "empty", int'(empty), 1);
      chk("R1", "full", int'(full), 0);
      chk("R1", "head_valid", int'(head_valid), 0);
      chk("R1", "rem_err", int'(rem_err), 0);

      // R4 / R2: mixed priorities land at head, middle and tail
      do_insert(5, 10); expect_head("R4");
      do_insert(2, 11); expect_head("R2");
      do_insert(7, 12); expect_head("R2");
      do_insert(2, 13); expect_head("R3");
      do_insert(0, 14); expect_head("R2");
      do_insert(5, 15); expect_head("R3");

      // R6: remove from the middle
      do_remove("R6", 10); expect_head("R6");
      // R7: remove the head, successor takes over
      do_remove("R7", 14); expect_head("R7");

      // R8: absent identifier, error pulse, list unchanged
      do_remove("R8", 99);
      expect_head("R8");
      @(negedge clk);
      chk("R8", "rem_err clears", int'(rem_err), 0);

      // R9: insert and remove in one cycle, insert dropped
      @(negedge clk);
      ins_valid = 1'b1; ins_prio = 4'd0; ins_kind = 2'd1; ins_id = 8'd50;
      rem_valid = 1'b1; rem_id = 8'd11;
      @(negedge clk);
      ins_valid = 1'b0; rem_valid = 1'b0;
      void'(model_remove(11));
      expect_head("R9");

      // R3 / R6: drain all and compare order
      drain("R3");

      // R5: fill every slot with repeated priorities
      for (int i = 0; i < NS; i++) do_insert(i % 3, 20 + i);
      chk("R5", "full", int'(full), 1);
      chk("R5", "empty", int'(empty), 0);
      @(negedge clk);
      ins_valid = 1'b1; ins_prio = 4'd0; ins_kind = 2'd3; ins_id = 8'd77;
      @(negedge clk);
      ins_valid = 1'b0;
      chk("R5", "full after dropped insert", int'(full), 1);
      expect_head("R5");
      drain("R5");

      // R10: freed slots are reused
      for (int i = 0; i < NS; i++) do_insert(15 - i, 100 + i);
      chk("R10", "full after refill", int'(full), 1);
      expect_head("R10");
      do_remove("R10", 107);
      chk("R10", "not full after remove", int'(full), 0);
      do_insert(4, 200);
      chk("R10", "full again", int'(full), 1);
      drain("R10");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule